// File: doc/BRIEF.md
# ADC Link Restart Sequencer

This block brings a multi-input ADC receive link back into service so that no corrupted data blocks reach the processing clock domain. When asked for a full restart, it first stops the block-number source. It then waits long enough for the clock-crossing FIFO to drain. Next it places the receive domain in reset through a control word that also carries one disable bit per input. It holds that reset across at least one full sync period. After releasing the reset and checking the control word by reading it back, it pulses a link re-initialisation bit in every input's link control register. Finally it waits for a sync pulse and turns the source back on.

A lighter mode performs only the per-input re-initialisation. This mode touches neither the source nor the reset, because the receive clock keeps running during a re-initialisation. All register traffic goes out over a simple single-beat memory-mapped master: one write or one read per cycle, with read data returned later together with a valid strobe. While the reset bit is set, the block also drives the gating signals for the receive clock enable, the receive reset and the forwarded sync pulse.

Top module: `link_restart_seq`

## Requirements
- R1: A start accepted in full mode (`full_mode_i`=1) makes the first bus write go to `SRC_EN_ADDR` with data 0.
- R2: The reset write goes to `CTRL_ADDR` with data having only bit 31 set. It appears no sooner than DRAIN_BLOCKS*BLOCK_LEN cycles after the source-off write, and at most two cycles later than that.
- R3: The reset stays set until the second `sync_i` pulse after it was asserted. In the cycle after that pulse, the block writes `CTRL_ADDR` with bit 31 clear and the start-time disable mask in bits N_IN-1:0. `ctrl_word_o` then holds that word.
- R4: While bit 31 of the control word is set, `rx_rst_o`=1, `rx_clk_en_o`=0 and `sysref_o`=0. Otherwise, `sysref_o` repeats `sync_i` one cycle later.
- R5: After the release write, the block issues one read of `CTRL_ADDR`. `rb_ok_o` is 1 exactly when the returned data equals the written word, and it keeps that value until the next accepted start.
- R6: The re-initialisation writes go to every input i in ascending order, at address LINK_BASE + i*PORT_SPAN + LINK_CTRL_OFS, with data 3: bit 0 is the re-init bit and bit 1 is the sync-always-on bit. REINIT_HOLD cycles later, the block rewrites each of these addresses in the same order with data 2.
- R7: In full mode, no source write follows the last rewrite until a `sync_i` pulse arrives. In the cycle after that pulse, the block writes `SRC_EN_ADDR` with data 1.
- R8: In re-init-only mode (`full_mode_i`=0), the only bus writes are those of R6. No write goes to the source or control address, and `rx_rst_o` stays 0.
- R9: `busy_o` is 1 from the cycle after an accepted start to the end of the sequence. `done_o` is a single-cycle pulse in the cycle `busy_o` falls.
- R10: A start that arrives while busy is ignored. It causes no extra bus traffic, neither then nor after the running sequence ends.
- R11: After reset, `busy_o`, `done_o`, `mm_wr_o` and `mm_rd_o` are 0, `ctrl_word_o` is 0 and `rx_clk_en_o` is 1.
- R12: `mm_wr_o` and `mm_rd_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a sequence when idle |
| full_mode_i | input | 1 | 1: drain, reset and re-init; 0: re-init only |
| dis_mask_i | input | N_IN | Per-input disable mask, sampled at start |
| sync_i | input | 1 | Sync (SYSREF) pulse |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| rb_ok_o | output | 1 | Control word read back matched |
| mm_wr_o | output | 1 | Bus write strobe |
| mm_rd_o | output | 1 | Bus read strobe |
| mm_addr_o | output | AW | Bus address |
| mm_wdata_o | output | 32 | Bus write data |
| mm_rdata_i | input | 32 | Bus read data |
| mm_rvalid_i | input | 1 | Bus read data valid |
| ctrl_word_o | output | 32 | Current control word (bit 31 reset, low bits disable mask) |
| rx_rst_o | output | 1 | Receive-domain reset |
| rx_clk_en_o | output | 1 | Receive clock enable |
| sysref_o | output | 1 | Forwarded sync pulse, gated during reset |

## Verification
The bench builds the block with four inputs, an eight-cycle block and a two-block drain, a five-cycle re-init hold, and a port span of 16. With these values the drain window can be checked to the exact cycle. They also cover the first, middle and last input addresses and the ascending order. The whole full sequence runs in a few dozen cycles, so the bench can place sync pulses by hand: one inside the reset hold, one at release and one at the final re-enable. A bus model that can corrupt read data exercises both outcomes of the readback check.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_DW            = 32;
  localparam int RS_RST_BIT       = 31;
  localparam int RS_REINIT_BIT    = 0;
  localparam int RS_SYSREF_ON_BIT = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_RST_HOLD,
    ST_RB_REQ,
    ST_RB_WAIT,
    ST_RI_SET,
    ST_RI_HOLD,
    ST_RI_CLR,
    ST_SYNC_WAIT
  } rs_state_e;
endpackage

// File: rtl/rs_timer.sv
module rs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rs_port_addr.sv
module rs_port_addr #(
  parameter int AW            = 16,
  parameter int IW            = 4,
  parameter int PORT_SPAN     = 256,
  parameter int LINK_BASE     = 0,
  parameter int LINK_CTRL_OFS = 4
) (
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] OFS  = AW'(LINK_BASE + LINK_CTRL_OFS);
  localparam logic [AW-1:0] SPAN = AW'(PORT_SPAN);

  assign addr_o = OFS + AW'(idx_i) * SPAN;
endmodule

// File: rtl/rs_fwd_gate.sv
module rs_fwd_gate (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic sync_i,
  output logic rx_rst_o,
  output logic rx_clk_en_o,
  output logic sysref_o
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync_i & ~hold_i;
  end

  assign sysref_o    = sync_q & ~hold_i;
  assign rx_rst_o    = hold_i;
  assign rx_clk_en_o = ~hold_i;
endmodule

// File: rtl/link_restart_seq.sv
module link_restart_seq
  import rs_pkg::*;
#(
  parameter int N_IN          = 12,
  parameter int AW            = 16,
  parameter int BLOCK_LEN     = 1024,
  parameter int DRAIN_BLOCKS  = 2,
  parameter int REINIT_HOLD   = 256,
  parameter int PORT_SPAN     = 256,
  parameter int LINK_BASE     = 0,
  parameter int LINK_CTRL_OFS = 4,
  parameter int SRC_EN_ADDR   = 'hF000,
  parameter int CTRL_ADDR     = 'hF100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              full_mode_i,
  input  logic [N_IN-1:0]   dis_mask_i,
  input  logic              sync_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rb_ok_o,
  output logic              mm_wr_o,
  output logic              mm_rd_o,
  output logic [AW-1:0]     mm_addr_o,
  output logic [RS_DW-1:0]  mm_wdata_o,
  input  logic [RS_DW-1:0]  mm_rdata_i,
  input  logic              mm_rvalid_i,
  output logic [RS_DW-1:0]  ctrl_word_o,
  output logic              rx_rst_o,
  output logic              rx_clk_en_o,
  output logic              sysref_o
);
  localparam int DRAIN_CYC = DRAIN_BLOCKS * BLOCK_LEN;
  localparam int MAX_WAIT  = (DRAIN_CYC > REINIT_HOLD) ? DRAIN_CYC : REINIT_HOLD;
  localparam int CW        = $clog2(MAX_WAIT + 1);
  localparam int IW        = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam logic [RS_DW-1:0] RST_WORD    = RS_DW'(1) << RS_RST_BIT;
  localparam logic [RS_DW-1:0] SYSON_WORD  = RS_DW'(1) << RS_SYSREF_ON_BIT;
  localparam logic [RS_DW-1:0] REINIT_WORD = SYSON_WORD | (RS_DW'(1) << RS_REINIT_BIT);
  localparam logic [AW-1:0]    SRC_A       = AW'(SRC_EN_ADDR);
  localparam logic [AW-1:0]    CTRL_A      = AW'(CTRL_ADDR);

  rs_state_e          state_q;
  logic               full_q;
  logic [N_IN-1:0]    mask_q;
  logic [IW-1:0]      idx_q;
  logic               sync_cnt_q;
  logic               rb_ok_q;
  logic               done_q;
  logic               wr_q, rd_q;
  logic [AW-1:0]      addr_q;
  logic [RS_DW-1:0]   wdata_q;
  logic [RS_DW-1:0]   ctrl_q;

  logic               tmr_load;
  logic [CW-1:0]      tmr_val;
  logic               tmr_expired;
  logic [AW-1:0]      port_addr;
  logic               idx_last;
  logic [RS_DW-1:0]   mask_word;

  assign idx_last  = (idx_q == IW'(N_IN - 1));
  assign mask_word = RS_DW'(mask_q);
  assign tmr_load  = (state_q == ST_IDLE && start_i && full_mode_i) ||
                     (state_q == ST_RI_SET && idx_last);
  assign tmr_val   = (state_q == ST_IDLE) ? CW'(DRAIN_CYC) : CW'(REINIT_HOLD);

  rs_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  rs_port_addr #(
    .AW(AW), .IW(IW), .PORT_SPAN(PORT_SPAN),
    .LINK_BASE(LINK_BASE), .LINK_CTRL_OFS(LINK_CTRL_OFS)
  ) u_addr (
    .idx_i  (idx_q),
    .addr_o (port_addr)
  );

  rs_fwd_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .hold_i      (ctrl_q[RS_RST_BIT]),
    .sync_i      (sync_i),
    .rx_rst_o    (rx_rst_o),
    .rx_clk_en_o (rx_clk_en_o),
    .sysref_o    (sysref_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      full_q     <= 1'b0;
      mask_q     <= '0;
      idx_q      <= '0;
      sync_cnt_q <= 1'b0;
      rb_ok_q    <= 1'b0;
      done_q     <= 1'b0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      ctrl_q     <= '0;
    end else begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            full_q  <= full_mode_i;
            mask_q  <= dis_mask_i;
            rb_ok_q <= 1'b0;
            idx_q   <= '0;
            if (full_mode_i) begin
              wr_q    <= 1'b1;
              addr_q  <= SRC_A;
              wdata_q <= '0;
              state_q <= ST_DRAIN;
            end else begin
              state_q <= ST_RI_SET;
            end
          end
        end
        ST_DRAIN: begin
          if (tmr_expired) begin
            wr_q       <= 1'b1;
            addr_q     <= CTRL_A;
            wdata_q    <= RST_WORD;
            ctrl_q     <= RST_WORD;
            sync_cnt_q <= 1'b0;
            state_q    <= ST_RST_HOLD;
          end
        end
        ST_RST_HOLD: begin
          if (sync_i) begin
            if (sync_cnt_q) begin
              wr_q    <= 1'b1;
              addr_q  <= CTRL_A;
              wdata_q <= mask_word;
              ctrl_q  <= mask_word;
              state_q <= ST_RB_REQ;
            end else begin
              sync_cnt_q <= 1'b1;
            end
          end
        end
        ST_RB_REQ: begin
          rd_q    <= 1'b1;
          addr_q  <= CTRL_A;
          state_q <= ST_RB_WAIT;
        end
        ST_RB_WAIT: begin
          if (mm_rvalid_i) begin
            rb_ok_q <= (mm_rdata_i == ctrl_q);
            state_q <= ST_RI_SET;
          end
        end
        ST_RI_SET: begin
          wr_q    <= 1'b1;
          addr_q  <= port_addr;
          wdata_q <= REINIT_WORD;
          if (idx_last) begin
            idx_q   <= '0;
            state_q <= ST_RI_HOLD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RI_HOLD: begin
          if (tmr_expired) state_q <= ST_RI_CLR;
        end
        ST_RI_CLR: begin
          wr_q    <= 1'b1;
          addr_q  <= port_addr;
          wdata_q <= SYSON_WORD;
          if (idx_last) begin
            idx_q <= '0;
            if (full_q) begin
              state_q <= ST_SYNC_WAIT;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SYNC_WAIT: begin
          if (sync_i) begin
            wr_q    <= 1'b1;
            addr_q  <= SRC_A;
            wdata_q <= RS_DW'(1);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign rb_ok_o     = rb_ok_q;
  assign mm_wr_o     = wr_q;
  assign mm_rd_o     = rd_q;
  assign mm_addr_o   = addr_q;
  assign mm_wdata_o  = wdata_q;
  assign ctrl_word_o = ctrl_q;
endmodule

// File: rtl/link_restart_seq_chk.sv
module link_restart_seq_chk #(
  parameter int AW          = 16,
  parameter int SRC_EN_ADDR = 'hF000,
  parameter int CTRL_ADDR   = 'hF100,
  parameter int DRAIN_CYC   = 2048
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          sync_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mm_wr_o,
  input logic          mm_rd_o,
  input logic [AW-1:0] mm_addr_o,
  input logic [31:0]   mm_wdata_o,
  input logic          rx_rst_o,
  input logic          sysref_o
);
  logic [31:0] gap_q;
  logic [1:0]  syncs_q;
  logic        src_off_w, rst_w;

  assign src_off_w = mm_wr_o && mm_addr_o == AW'(SRC_EN_ADDR) && mm_wdata_o == 32'd0;
  assign rst_w     = mm_wr_o && mm_addr_o == AW'(CTRL_ADDR) && mm_wdata_o[31];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      syncs_q <= '0;
    end else begin
      if (src_off_w)           gap_q <= '0;
      else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
      if (!rx_rst_o)           syncs_q <= '0;
      else if (sync_i && syncs_q != 2'd3) syncs_q <= syncs_q + 1'b1;
    end
  end

  // R2
  drain_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rst_w |-> gap_q >= 32'(DRAIN_CYC));
  // R3
  rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_rst_o) |-> syncs_q >= 2'd2);
  // R4
  sysref_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sysref_o) |-> $past(sync_i));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));
  // R12
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mm_wr_o && mm_rd_o));
endmodule

bind link_restart_seq link_restart_seq_chk #(
  .AW(AW), .SRC_EN_ADDR(SRC_EN_ADDR), .CTRL_ADDR(CTRL_ADDR), .DRAIN_CYC(DRAIN_CYC)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .sync_i(sync_i), .busy_o(busy_o),
  .done_o(done_o), .mm_wr_o(mm_wr_o), .mm_rd_o(mm_rd_o), .mm_addr_o(mm_addr_o),
  .mm_wdata_o(mm_wdata_o), .rx_rst_o(rx_rst_o), .sysref_o(sysref_o)
);

// File: tb/link_restart_seq_tb.sv
module link_restart_seq_tb;
  localparam int N_IN = 4;
  localparam int AW = 12;
  localparam int BLOCK_LEN = 8;
  localparam int DRAIN_BLOCKS = 2;
  localparam int DRAIN_CYC = BLOCK_LEN * DRAIN_BLOCKS;
  localparam int REINIT_HOLD = 5;
  localparam int PORT_SPAN = 16;
  localparam int LINK_OFS = 3;
  localparam int SRC_A = 'h200;
  localparam int CTRL_A = 'h300;

  logic clk = 0, rst = 1;
  logic start_i = 0, full_mode_i = 0, sync_i = 0;
  logic [N_IN-1:0] dis_mask_i = '0;
  logic busy_o, done_o, rb_ok_o, mm_wr_o, mm_rd_o;
  logic [AW-1:0] mm_addr_o;
  logic [31:0] mm_wdata_o, ctrl_word_o;
  logic [31:0] mm_rdata_i = '0;
  logic mm_rvalid_i = 0;
  logic rx_rst_o, rx_clk_en_o, sysref_o;

  always #4 clk = ~clk;

  link_restart_seq #(
    .N_IN(N_IN), .AW(AW), .BLOCK_LEN(BLOCK_LEN), .DRAIN_BLOCKS(DRAIN_BLOCKS),
    .REINIT_HOLD(REINIT_HOLD), .PORT_SPAN(PORT_SPAN), .LINK_BASE(0),
    .LINK_CTRL_OFS(LINK_OFS), .SRC_EN_ADDR(SRC_A), .CTRL_ADDR(CTRL_A)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .full_mode_i(full_mode_i),
    .dis_mask_i(dis_mask_i), .sync_i(sync_i), .busy_o(busy_o), .done_o(done_o),
    .rb_ok_o(rb_ok_o), .mm_wr_o(mm_wr_o), .mm_rd_o(mm_rd_o), .mm_addr_o(mm_addr_o),
    .mm_wdata_o(mm_wdata_o), .mm_rdata_i(mm_rdata_i), .mm_rvalid_i(mm_rvalid_i),
    .ctrl_word_o(ctrl_word_o), .rx_rst_o(rx_rst_o), .rx_clk_en_o(rx_clk_en_o),
    .sysref_o(sysref_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  typedef struct { logic [AW-1:0] a; logic [31:0] d; string tag; } exp_t;
  exp_t exq[$];
  exp_t e;
  logic [31:0] mem [int];
  logic [31:0] corrupt = '0;
  int nwr = 0, nsrc_off = 0, nsrc_on = 0, nctrl = 0, nclr = 0, ndone = 0;
  int src_cyc = 0, rst_cyc = 0;
  bit rst_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int a, input logic [31:0] d, input string tag);
    exp_t x;
    x.a = AW'(a); x.d = d; x.tag = tag;
    exq.push_back(x);
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor and bus model
  always @(negedge clk) begin
    mm_rvalid_i = 1'b0;
    if (!rst) begin
      if (mm_wr_o && mm_rd_o) chk(0, "R12", "write and read together", 1, 0);
      if (mm_wr_o) begin
        mem[int'(mm_addr_o)] = mm_wdata_o;
        nwr++;
        if (exq.size() == 0) chk(0, "R10", "unexpected write", 32'(mm_addr_o), 0);
        else begin
          e = exq.pop_front();
          chk(mm_addr_o == e.a, e.tag, "write addr", 32'(mm_addr_o), 32'(e.a));
          chk(mm_wdata_o == e.d, e.tag, "write data", mm_wdata_o, e.d);
        end
        if (mm_addr_o == AW'(SRC_A)) begin
          if (mm_wdata_o == 0) begin nsrc_off++; src_cyc = cyc; end
          else nsrc_on++;
        end else if (mm_addr_o == AW'(CTRL_A)) begin
          nctrl++;
          if (mm_wdata_o[31]) rst_cyc = cyc;
        end else if (mm_wdata_o == 32'd2) nclr++;
      end
      if (mm_rd_o) begin
        mm_rvalid_i = 1'b1;
        mm_rdata_i = (mem.exists(int'(mm_addr_o)) ? mem[int'(mm_addr_o)] : 32'd0) ^ corrupt;
      end
      if (rx_rst_o) rst_seen = 1;
      if (done_o) ndone++;
    end
  end

  task automatic reset_counts();
    nwr = 0; nsrc_off = 0; nsrc_on = 0; nctrl = 0; nclr = 0; ndone = 0; rst_seen = 0;
  endtask

  task automatic push_links();
    for (int i = 0; i < N_IN; i++) push(LINK_OFS + i * PORT_SPAN, 32'd3, "R6");
    for (int i = 0; i < N_IN; i++) push(LINK_OFS + i * PORT_SPAN, 32'd2, "R6");
  endtask

  task automatic full_run(input logic [N_IN-1:0] mask, input logic [31:0] corr, input bit exp_ok);
    int w;
    int nw;
    reset_counts();
    corrupt = corr;
    push(SRC_A, 32'd0, "R1");
    push(CTRL_A, 32'h8000_0000, "R2");
    push(CTRL_A, 32'(mask), "R3");
    push_links();
    push(SRC_A, 32'd1, "R7");
    tick(); start_i = 1; full_mode_i = 1; dis_mask_i = mask;
    tick(); start_i = 0; dis_mask_i = '0;
    chk(busy_o == 1, "R9", "busy after start", 32'(busy_o), 1);
    w = 0;
    while (!rx_rst_o && w < 1000) begin tick(); w++; end
    tick();
    chk((rst_cyc - src_cyc) >= DRAIN_CYC && (rst_cyc - src_cyc) <= DRAIN_CYC + 2,
        "R2", "drain gap", 32'(rst_cyc - src_cyc), 32'(DRAIN_CYC + 1));
    chk(rx_clk_en_o == 0 && ctrl_word_o == 32'h8000_0000, "R4", "clock gated in reset",
        32'(rx_clk_en_o), 0);
    // R10: start while busy
    start_i = 1; full_mode_i = 1; tick(); start_i = 0;
    // first sync inside the hold
    sync_i = 1; tick(); sync_i = 0;
    chk(sysref_o == 0, "R4", "sysref gated", 32'(sysref_o), 0);
    repeat (3) tick();
    chk(nctrl == 1 && rx_rst_o == 1, "R3", "reset still held after one sync", 32'(nctrl), 1);
    // second sync releases
    sync_i = 1; tick(); sync_i = 0;
    chk(mm_wr_o && mm_addr_o == AW'(CTRL_A), "R3", "release write after second sync",
        32'(mm_addr_o), 32'(CTRL_A));
    chk(ctrl_word_o == 32'(mask) && rx_rst_o == 0, "R3", "control word after release",
        ctrl_word_o, 32'(mask));
    w = 0;
    while (nclr < N_IN && w < 1000) begin tick(); w++; end
    repeat (5) tick();
    chk(busy_o == 1 && nsrc_on == 0, "R7", "no re-enable before sync", 32'(nsrc_on), 0);
    chk(rb_ok_o == exp_ok, "R5", "readback flag", 32'(rb_ok_o), 32'(exp_ok));
    sync_i = 1; tick(); sync_i = 0;
    chk(mm_wr_o && mm_addr_o == AW'(SRC_A) && done_o, "R7", "re-enable with done",
        32'(mm_addr_o), 32'(SRC_A));
    chk(sysref_o == 1, "R4", "sysref passes out of reset", 32'(sysref_o), 1);
    tick();
    chk(done_o == 0 && busy_o == 0, "R9", "done one cycle", 32'(done_o), 0);
    nw = nwr;
    repeat (10) tick();
    chk(exq.size() == 0 && nwr == nw && busy_o == 0, "R10", "no traffic from ignored start",
        32'(nwr), 32'(nw));
    chk(ndone == 1, "R9", "done count", 32'(ndone), 1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    chk(!busy_o && !done_o && !mm_wr_o && !mm_rd_o, "R11", "idle after reset", 32'(busy_o), 0);
    chk(ctrl_word_o == 0 && rx_clk_en_o == 1, "R11", "control word after reset", ctrl_word_o, 0);
    sync_i = 1; tick(); sync_i = 0;
    chk(sysref_o == 1, "R4", "sysref follows sync", 32'(sysref_o), 1);

    full_run(4'b0100, 32'd0, 1'b1);
    full_run(4'b1001, 32'h0000_0010, 1'b0);

    // re-init only
    reset_counts();
    push_links();
    tick(); start_i = 1; full_mode_i = 0;
    tick(); start_i = 0;
    begin
      int w = 0;
      while (busy_o && w < 1000) begin tick(); w++; end
    end
    repeat (3) tick();
    chk(nsrc_off == 0 && nsrc_on == 0 && nctrl == 0, "R8", "no source or control writes",
        32'(nctrl + nsrc_off + nsrc_on), 0);
    chk(rst_seen == 0, "R8", "reset never asserted", 32'(rst_seen), 0);
    chk(exq.size() == 0 && ndone == 1, "R8", "all link writes seen", 32'(exq.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule